// File: doc/BRIEF.md
# Channel Parallel Input Multiplexer

This block sits at the front of one channel of a sigma-delta filter bank. It decides where the channel's samples come from. The choices are the serial bitstream path, which is handled elsewhere, the 16-bit result of the converter paired with this channel, or 16-bit words that a processor or DMA engine writes. The block holds the channel's data-input register. Every time that register is loaded, the block hands the new signed 16-bit value to the filter together with a one-cycle valid strobe.

Channel y is tied to converter y+1 (counting converters from 1). The top therefore takes the result and end-of-conversion lines of every converter, and the channel index parameter picks its own lane. The register is protected against bus writes whenever a parallel source is not selected. It is also protected in converter mode, where only end-of-conversion events may load it.

Top module: `ch_par_input_mux`

## Requirements
- R1: After a synchronous active-low reset, the readback `din_rdata` is zero and `smp_valid` is low.
- R2: With `src_sel` = 0 (serial), bus writes and end-of-conversion events leave the register unchanged, `smp_valid` stays low, and `par_active` is low.
- R3: With `src_sel` = 1 (converter), an end-of-conversion pulse on lane CHAN_IDX (0-based lane, i.e. converter CHAN_IDX+1) loads that lane's 16-bit result into the register low half on the next clock edge, and `smp_valid` is high for that one cycle. Pulses on other lanes have no effect.
- R4: With `src_sel` = 1, bus writes are ignored. When a bus write and an end-of-conversion fall in the same cycle, the converter result is stored.
- R5: With `src_sel` = 2 (direct write), a bus write stores `bus_wr_data` in the register low half on the next edge, and `smp_valid` pulses for one cycle.
- R6: With `src_sel` = 2, end-of-conversion events are ignored.
- R7: `src_sel` = 3 is reserved and behaves exactly like serial mode: no load, no valid, `par_active` low.
- R8: Bits 31:16 of `din_rdata` always read zero; bits 15:0 hold the last stored sample.
- R9: `smp_data` equals the register low half. Loads on consecutive cycles each produce their own valid cycle, one per load.
- R10: `par_active` is high exactly when `src_sel` is 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Source code: 0 serial, 1 converter, 2 direct write, 3 reserved |
| bus_wr_en | input | 1 | Bus write strobe for the data-input register |
| bus_wr_data | input | 16 | Write data for the register low half |
| conv_eoc | input | NUM_CONV (8) | End-of-conversion pulses, one per converter lane |
| conv_result | input | NUM_CONV*16 (128) | Converter results, lane k in bits 16k+15:16k |
| par_active | output | 1 | A parallel source is selected; the filter ignores the serial path |
| smp_valid | output | 1 | One-cycle strobe: a new sample is in `smp_data` |
| smp_data | output | 16 | Signed sample forwarded to the filter |
| din_rdata | output | 32 | Readback of the data-input register |

## Verification
Two loads can fall in the same cycle: an end-of-conversion on the channel's own lane and a bus write. Only the source code decides which of them may take effect. The bench drives both strobes together in converter mode, in direct mode and in the protected modes. It also drives eoc on neighbouring lanes at the same time. A behavioural model, updated every clock, predicts the register, the strobe and the forwarded sample, and the bench compares them one edge later. A wrong winner or a leaked write shows up as a mismatch in the stored value or in the valid cycle.

// File: rtl/chmux_pkg.sv
// Package: shared source codes and sample width for the channel input mux.
// Assumes: src_sel codes are fixed by the register field layout.
package chmux_pkg;
    localparam int SMP_W = 16;

    typedef enum logic [1:0] {
        SRC_SERIAL = 2'd0,
        SRC_CONV   = 2'd1,
        SRC_DIRECT = 2'd2,
        SRC_RSVD   = 2'd3
    } src_mode_e;
endpackage

// File: rtl/chmux_src_decode.sv
// Module: decodes the 2-bit source field into per-source enables.
// Assumes: reserved code is treated as serial (no parallel source).
module chmux_src_decode
    import chmux_pkg::*;
(
    input  logic [1:0] src_sel,
    output logic       conv_mode,
    output logic       direct_mode,
    output logic       par_active
);
    src_mode_e mode;

    // Purpose: map the raw field to one enable per parallel source.
    always_comb begin
        mode        = src_mode_e'(src_sel);
        conv_mode   = 1'b0;
        direct_mode = 1'b0;
        unique case (mode)
            SRC_CONV:   conv_mode   = 1'b1;
            SRC_DIRECT: direct_mode = 1'b1;
            default: begin
                conv_mode   = 1'b0;
                direct_mode = 1'b0;
            end
        endcase
        par_active = conv_mode | direct_mode;
    end
endmodule

// File: rtl/chmux_conv_pick.sv
// Module: extracts the paired converter lane (lane CHAN_IDX) from the
// bundle of all converter results and end-of-conversion pulses.
// Assumes: CHAN_IDX < NUM_CONV; an out-of-range index yields no events.
module chmux_conv_pick #(
    parameter int NUM_CONV = 8,
    parameter int CHAN_IDX = 0,
    parameter int SMP_W    = 16
) (
    input  logic [NUM_CONV-1:0]       eoc_all,
    input  logic [NUM_CONV*SMP_W-1:0] res_all,
    output logic                      eoc_sel,
    output logic [SMP_W-1:0]          res_sel
);
    logic [NUM_CONV-1:0] hit;
    logic [SMP_W-1:0]    lane_masked [NUM_CONV];

    // One masked copy per lane; only the paired lane passes.
    for (genvar k = 0; k < NUM_CONV; k++) begin : g_lane
        localparam bit MINE = (k == CHAN_IDX);
        assign hit[k]         = eoc_all[k] & MINE;
        assign lane_masked[k] = res_all[k*SMP_W +: SMP_W] & {SMP_W{MINE}};
    end

    // Purpose: OR-reduce the masked lanes into the selected pair.
    always_comb begin
        res_sel = '0;
        for (int k = 0; k < NUM_CONV; k++) begin
            res_sel = res_sel | lane_masked[k];
        end
        eoc_sel = |hit;
    end
endmodule

// File: rtl/chmux_din_reg.sv
// Module: data-input register low half plus the sample-valid strobe.
// Assumes: at most one of conv_mode/direct_mode is high; converter
// mode loads only on eoc, direct mode only on bus writes.
module chmux_din_reg #(
    parameter int SMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_mode,
    input  logic             direct_mode,
    input  logic             eoc,
    input  logic [SMP_W-1:0] conv_res,
    input  logic             bus_wr,
    input  logic [SMP_W-1:0] bus_data,
    output logic [SMP_W-1:0] lo_q,
    output logic             valid_q
);
    logic             load;
    logic [SMP_W-1:0] load_data;

    // Purpose: choose the permitted load source for this cycle.
    always_comb begin
        load      = 1'b0;
        load_data = lo_q;
        if (conv_mode && eoc) begin
            load      = 1'b1;
            load_data = conv_res;
        end else if (direct_mode && bus_wr) begin
            load      = 1'b1;
            load_data = bus_data;
        end
    end

    // Purpose: store the sample and raise valid for exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) lo_q <= load_data;
        end
    end

    AST_PROTECTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_mode && !direct_mode) |=> ($stable(lo_q) && !valid_q)); // R2
    AST_DIRECT_EOC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode && !bus_wr) |=> (!valid_q && $stable(lo_q))); // R6
endmodule

// File: rtl/ch_par_input_mux.sv
// Module: top of the channel parallel input multiplexer. Picks the
// paired converter lane, decodes the source field, keeps the data-input
// register and forwards each load to the filter as a strobed sample.
// Assumes: synchronous active-low reset; REG_W >= SMP_W.
module ch_par_input_mux
    import chmux_pkg::*;
#(
    parameter int NUM_CONV = 8,
    parameter int CHAN_IDX = 0,
    parameter int REG_W    = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                src_sel,
    input  logic                      bus_wr_en,
    input  logic [SMP_W-1:0]          bus_wr_data,
    input  logic [NUM_CONV-1:0]       conv_eoc,
    input  logic [NUM_CONV*SMP_W-1:0] conv_result,
    output logic                      par_active,
    output logic                      smp_valid,
    output logic [SMP_W-1:0]          smp_data,
    output logic [REG_W-1:0]          din_rdata
);
    localparam int PAD_W = REG_W - SMP_W;

    logic             conv_mode;
    logic             direct_mode;
    logic             eoc_sel;
    logic [SMP_W-1:0] res_sel;
    logic [SMP_W-1:0] lo_q;

    chmux_src_decode u_dec (
        .src_sel     (src_sel),
        .conv_mode   (conv_mode),
        .direct_mode (direct_mode),
        .par_active  (par_active)
    );

    chmux_conv_pick #(
        .NUM_CONV (NUM_CONV),
        .CHAN_IDX (CHAN_IDX),
        .SMP_W    (SMP_W)
    ) u_pick (
        .eoc_all (conv_eoc),
        .res_all (conv_result),
        .eoc_sel (eoc_sel),
        .res_sel (res_sel)
    );

    chmux_din_reg #(
        .SMP_W (SMP_W)
    ) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .conv_mode   (conv_mode),
        .direct_mode (direct_mode),
        .eoc         (eoc_sel),
        .conv_res    (res_sel),
        .bus_wr      (bus_wr_en),
        .bus_data    (bus_wr_data),
        .lo_q        (lo_q),
        .valid_q     (smp_valid)
    );

    // Purpose: forward the stored sample and zero-extend the readback.
    always_comb begin
        smp_data  = lo_q;
        din_rdata = {{PAD_W{1'b0}}, lo_q};
    end

    AST_CONV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd1 && conv_eoc[CHAN_IDX])
        |=> (smp_valid && smp_data == $past(conv_result[CHAN_IDX*SMP_W +: SMP_W]))); // R3
    AST_CONV_BUS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd1 && !conv_eoc[CHAN_IDX]) |=> (!smp_valid && $stable(din_rdata))); // R4
    AST_DIRECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd2 && bus_wr_en) |=> (smp_valid && smp_data == $past(bus_wr_data))); // R5
    AST_RSVD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd3) |=> (!smp_valid && $stable(din_rdata))); // R7
endmodule

// File: tb/ch_par_input_mux_tb.sv
// Bench: behavioural reference model updated on each clock, compared
// against the outputs a quarter period after every rising edge.
module ch_par_input_mux_tb_top;
    localparam int T_CLK = 10;
    localparam int NCONV = 8;
    localparam int CIDX  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       src_sel = 2'd0;
    logic             bus_wr_en = 1'b0;
    logic [15:0]      bus_wr_data = '0;
    logic [NCONV-1:0] conv_eoc = '0;
    logic [NCONV*16-1:0] conv_result = '0;
    logic             par_active;
    logic             smp_valid;
    logic [15:0]      smp_data;
    logic [31:0]      din_rdata;

    int n_run = 0;
    int n_fail = 0;
    string tag = "R1";

    int m_lo = 0;
    bit m_valid = 1'b0;

    always #(T_CLK/2) clk = ~clk;

    ch_par_input_mux #(.NUM_CONV(NCONV), .CHAN_IDX(CIDX), .REG_W(32)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .bus_wr_en(bus_wr_en),
        .bus_wr_data(bus_wr_data), .conv_eoc(conv_eoc), .conv_result(conv_result),
        .par_active(par_active), .smp_valid(smp_valid), .smp_data(smp_data),
        .din_rdata(din_rdata)
    );

    // Reference model: converter mode takes only its lane's eoc, direct
    // mode takes only bus writes, every other code holds the register.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lo = 0;
            m_valid = 1'b0;
        end else begin
            m_valid = 1'b0;
            if (src_sel == 2'd1) begin
                if (conv_eoc[CIDX]) begin
                    m_lo = int'(conv_result[CIDX*16 +: 16]);
                    m_valid = 1'b1;
                end
            end else if (src_sel == 2'd2) begin
                if (bus_wr_en) begin
                    m_lo = int'(bus_wr_data);
                    m_valid = 1'b1;
                end
            end
        end
    end

    task automatic compare();
        bit exp_par;
        logic [31:0] exp_rd;
        exp_par = (src_sel == 2'd1) || (src_sel == 2'd2);
        exp_rd = 32'(m_lo) & 32'h0000_FFFF;
        n_run++;
        if (din_rdata !== exp_rd || smp_valid !== m_valid ||
            smp_data !== exp_rd[15:0] || par_active !== exp_par) begin
            n_fail++;
            $display("FAIL %s: rd=%h v=%b d=%h par=%b expected rd=%h v=%b d=%h par=%b",
                     tag, din_rdata, smp_valid, smp_data, par_active,
                     exp_rd, m_valid, exp_rd[15:0], exp_par);
        end
    endtask

    task automatic cyc(input string t, input logic [1:0] sel, input logic wr,
                       input logic [15:0] wd, input logic [NCONV-1:0] eoc);
        tag = t;
        src_sel = sel;
        bus_wr_en = wr;
        bus_wr_data = wd;
        conv_eoc = eoc;
        @(posedge clk);
        #(T_CLK/4);
        compare();
    endtask

    task automatic set_lanes(input logic [15:0] base);
        for (int k = 0; k < NCONV; k++) conv_result[k*16 +: 16] = base + 16'(k * 16'h0101);
    endtask

    initial begin
        #(T_CLK * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int lfsr;
        set_lanes(16'hA000);
        rst_n = 1'b0;
        cyc("R1", 2'd2, 1'b1, 16'h5555, '1);
        cyc("R1", 2'd1, 1'b0, 16'h0, '1);
        rst_n = 1'b1;
        cyc("R1", 2'd0, 1'b0, 16'h0, '0);
        // serial: protected
        cyc("R2", 2'd0, 1'b1, 16'h1234, '0);
        cyc("R2", 2'd0, 1'b1, 16'hABCD, 8'b0000_1000);
        // direct writes, back-to-back, negative value
        cyc("R5", 2'd2, 1'b1, 16'h8001, '0);
        cyc("R8", 2'd2, 1'b1, 16'hFFFF, '0);
        cyc("R9", 2'd2, 1'b1, 16'h0123, '0);
        cyc("R9", 2'd2, 1'b0, 16'h7777, '0);
        // direct: eoc ignored, also when simultaneous with a write
        cyc("R6", 2'd2, 1'b0, 16'h0, 8'b0000_1000);
        cyc("R6", 2'd2, 1'b1, 16'h4242, 8'b0000_1000);
        // converter mode
        set_lanes(16'hF00F);
        cyc("R3", 2'd1, 1'b0, 16'h0, 8'b0000_1000);
        cyc("R3", 2'd1, 1'b0, 16'h0, 8'b1111_0111);
        cyc("R4", 2'd1, 1'b1, 16'h3333, '0);
        set_lanes(16'h1200);
        cyc("R4", 2'd1, 1'b1, 16'h3333, 8'b0000_1000);
        set_lanes(16'h0450);
        cyc("R9", 2'd1, 1'b0, 16'h0, 8'b0000_1000);
        cyc("R10", 2'd1, 1'b0, 16'h0, '0);
        // reserved code
        cyc("R7", 2'd3, 1'b1, 16'h9999, '1);
        cyc("R7", 2'd3, 1'b0, 16'h0, '1);
        cyc("R2", 2'd0, 1'b1, 16'h9999, '1);
        // mixed stimulus
        lfsr = 32'h1ACE;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr << 1) ^ ((lfsr >>> 31) & 1 ? 32'h04C1_1DB7 : 0);
            set_lanes(16'(lfsr >> 8));
            cyc("R9", 2'(lfsr >> 3), lfsr[5], 16'(lfsr >> 12), 8'(lfsr >> 20));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule